// File: doc/BRIEF.md
# Issue-Group Read-After-Write Checker

This block sits in the front end of an in-order, multi-issue pipeline. Each cycle it can take one group of decoded register-to-register instructions. Each slot in the group has:

- one destination register with its own enable bit;
- two source registers, each with its own enable bit;
- a slot-valid bit.

Slot 0 is the oldest instruction in the group. Every slot is checked against the destinations of all slots older than it. A flag is raised when a source would read a value that an earlier member of the same group has not yet produced.

From these flags the block works out how many leading instructions may issue together in one cycle. That count is the number of slots before the first one that either has such a hit or is not valid. Write-after-read and write-after-write conflicts are not checked. A later renaming stage removes them.

Each older/younger pair uses exactly two comparators, one per source of the younger slot. A group of N slots therefore uses N²−N comparators. The hit vector and the count are registered, so they appear one clock after the group is presented.

Top module: `depchk_top`

## Requirements
- R1: While `rst` is high, `out_valid`, `raw_hit` and `issue_cnt` are zero at the next clock edge, whatever the inputs are.
- R2: A group presented with `in_valid` high at a rising edge has its results on the outputs, with `out_valid` high, after that edge. `out_valid` is low after any edge at which `in_valid` was low.
- R3: `raw_hit[i]` is 1 exactly when some older slot j < i has its destination enable set, and that destination equals an enabled source A or an enabled source B of slot i. Slot k's fields sit at bits `k*REG_W +: REG_W` of each packed register bus.
- R4: `raw_hit[0]` is always 0, because slot 0 has no older slot.
- R5: Register index 0 never produces a hit, even when both enables are set and the indices match.
- R6: A comparison counts only when both of these are set: the older slot's destination enable, and the enable of the younger slot's matching source.
- R7: No hit is raised in either of these cases:
  - a younger slot's destination equals an older slot's source (write-after-read);
  - a younger slot's destination equals an older slot's destination (write-after-write).
- R8: `issue_cnt` is the lowest index i for which `raw_hit[i]` is 1 or `slot_vld[i]` is 0. It equals SLOTS when no slot blocks.
- R9: `slot_vld` has no effect on `raw_hit`. An invalid older slot with an enabled destination still flags a younger reader.
- R10: After an edge at which `in_valid` is low, `raw_hit` and `issue_cnt` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A group is presented this cycle |
| slot_vld | input | SLOTS | Per-slot instruction valid |
| slot_dst | input | SLOTS*REG_W | Packed destination indices |
| slot_dst_en | input | SLOTS | Destination enable per slot |
| slot_sa | input | SLOTS*REG_W | Packed source A indices |
| slot_sa_en | input | SLOTS | Source A enable per slot |
| slot_sb | input | SLOTS*REG_W | Packed source B indices |
| slot_sb_en | input | SLOTS | Source B enable per slot |
| out_valid | output | 1 | Registered results belong to a group |
| raw_hit | output | SLOTS | Per-slot in-group read-after-write flag |
| issue_cnt | output | $clog2(SLOTS+1) | Length of the issuable leading run |

## Verification
The bench builds the checker with SLOTS = 4 and REG_W = 3. With only eight register names, random groups frequently produce matches, including matches on index 0 and on both sources at once. Every issue count from 0 to 4 is therefore reached often.

Four slots also make the full pair triangle small enough to cover fully:

- every older/younger pairing;
- hits on source B only;
- write-after-read and write-after-write lookalikes;
- an invalid writer ahead of a valid reader.

A pairwise software model compares every result against its expected value.

// File: rtl/depchk_pkg.sv
package depchk_pkg;

  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_REG_W = 5;

  // width of a field that holds 0..slots inclusive
  function automatic int unsigned cnt_width(int unsigned slots);
    return $clog2(slots + 1);
  endfunction

  // two comparators for each (older, younger) pair
  function automatic int unsigned cmp_total(int unsigned slots);
    return slots * slots - slots;
  endfunction

endpackage

// File: rtl/depchk_pair.sv
// One older/younger pair: the older destination against both younger sources.
module depchk_pair #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] older_dst,
  input  logic             older_dst_en,
  input  logic [REG_W-1:0] yng_sa,
  input  logic             yng_sa_en,
  input  logic [REG_W-1:0] yng_sb,
  input  logic             yng_sb_en,
  output logic             hit
);

  logic writer_live;
  logic match_a;
  logic match_b;

  // index zero is hard-wired and never carries a dependence
  assign writer_live = older_dst_en && (older_dst != '0);
  assign match_a     = yng_sa_en && (yng_sa == older_dst);
  assign match_b     = yng_sb_en && (yng_sb == older_dst);
  assign hit         = writer_live && (match_a || match_b);

endmodule

// File: rtl/depchk_matrix.sv
// Lower-triangular comparator array: row i holds one pair cell per older slot j < i.
module depchk_matrix #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned REG_W = 5
) (
  input  logic [SLOTS*REG_W-1:0] slot_dst,
  input  logic [SLOTS-1:0]       slot_dst_en,
  input  logic [SLOTS*REG_W-1:0] slot_sa,
  input  logic [SLOTS-1:0]       slot_sa_en,
  input  logic [SLOTS*REG_W-1:0] slot_sb,
  input  logic [SLOTS-1:0]       slot_sb_en,
  output logic [SLOTS-1:0]       raw
);

  localparam int unsigned CELLS = SLOTS * SLOTS;

  logic [CELLS-1:0] hitf;

  for (genvar i = 0; i < SLOTS; i++) begin : g_row
    for (genvar j = 0; j < SLOTS; j++) begin : g_col
      if (j < i) begin : g_cell
        depchk_pair #(.REG_W(REG_W)) u_pair (
          .older_dst    (slot_dst[j*REG_W +: REG_W]),
          .older_dst_en (slot_dst_en[j]),
          .yng_sa       (slot_sa[i*REG_W +: REG_W]),
          .yng_sa_en    (slot_sa_en[i]),
          .yng_sb       (slot_sb[i*REG_W +: REG_W]),
          .yng_sb_en    (slot_sb_en[i]),
          .hit          (hitf[i*SLOTS + j])
        );
      end else begin : g_none
        assign hitf[i*SLOTS + j] = 1'b0;
      end
    end

    assign raw[i] = |hitf[i*SLOTS +: SLOTS];

    // a flagged row must have at least one enabled source
    always_comb begin
      AST_ROW_NEEDS_SOURCE: assert (!raw[i] || slot_sa_en[i] || slot_sb_en[i]); // R6
    end
  end

endmodule

// File: rtl/depchk_prefix.sv
// Finds the first blocked slot, scanning from the youngest down to the oldest.
module depchk_prefix #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic [SLOTS-1:0] raw,
  input  logic [SLOTS-1:0] vld,
  output logic [CNT_W-1:0] cnt
);

  logic [SLOTS-1:0] blk;

  assign blk = raw | ~vld;

  always_comb begin
    cnt = CNT_W'(SLOTS);
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (blk[i]) cnt = CNT_W'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      if (CNT_W'(i) < cnt) begin
        AST_RUN_UNBLOCKED: assert (vld[i] && !raw[i]); // R8
      end
    end
  end

endmodule

// File: rtl/depchk_top.sv
module depchk_top
  import depchk_pkg::*;
#(
  parameter  int unsigned SLOTS = DEF_SLOTS,
  parameter  int unsigned REG_W = DEF_REG_W,
  localparam int unsigned CNT_W = cnt_width(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [SLOTS-1:0]       slot_vld,
  input  logic [SLOTS*REG_W-1:0] slot_dst,
  input  logic [SLOTS-1:0]       slot_dst_en,
  input  logic [SLOTS*REG_W-1:0] slot_sa,
  input  logic [SLOTS-1:0]       slot_sa_en,
  input  logic [SLOTS*REG_W-1:0] slot_sb,
  input  logic [SLOTS-1:0]       slot_sb_en,
  output logic                   out_valid,
  output logic [SLOTS-1:0]       raw_hit,
  output logic [CNT_W-1:0]       issue_cnt
);

  logic [SLOTS-1:0] raw_c;
  logic [CNT_W-1:0] cnt_c;

  depchk_matrix #(.SLOTS(SLOTS), .REG_W(REG_W)) u_matrix (
    .slot_dst    (slot_dst),
    .slot_dst_en (slot_dst_en),
    .slot_sa     (slot_sa),
    .slot_sa_en  (slot_sa_en),
    .slot_sb     (slot_sb),
    .slot_sb_en  (slot_sb_en),
    .raw         (raw_c)
  );

  depchk_prefix #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_prefix (
    .raw (raw_c),
    .vld (slot_vld),
    .cnt (cnt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      raw_hit   <= '0;
      issue_cnt <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        raw_hit   <= raw_c;
        issue_cnt <= cnt_c;
      end
    end
  end

  // slots below the reported count
  logic [SLOTS-1:0] below_cnt;
  assign below_cnt = ~({SLOTS{1'b1}} << issue_cnt);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(raw_hit) && $stable(issue_cnt))); // R10

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    issue_cnt <= CNT_W'(SLOTS)); // R8

  AST_PREFIX_CLEAN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((raw_hit & below_cnt) == '0)); // R8

endmodule

// File: tb/depchk_top_test.sv
module depchk_top_test;

  localparam int N  = 4;
  localparam int RW = 3;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N-1:0]  vld = '0, den = '0, aen = '0, ben = '0;
  logic [N*RW-1:0] dst = '0, sa = '0, sb = '0;
  logic          out_valid;
  logic [N-1:0]  raw_hit;
  logic [CW-1:0] issue_cnt;

  depchk_top #(.SLOTS(N), .REG_W(RW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .slot_vld(vld),
    .slot_dst(dst), .slot_dst_en(den), .slot_sa(sa), .slot_sa_en(aen),
    .slot_sb(sb), .slot_sb_en(ben), .out_valid(out_valid),
    .raw_hit(raw_hit), .issue_cnt(issue_cnt)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0]  q_raw[$];
  logic [CW-1:0] q_cnt[$];
  string         q_tag[$];

  // pairwise model of the in-group read-after-write rule
  function automatic logic [N-1:0] ref_raw();
    logic [N-1:0] r = '0;
    for (int i = 1; i < N; i++)
      for (int j = 0; j < i; j++) begin
        logic [RW-1:0] d = dst[j*RW +: RW];
        if (den[j] && d != '0 &&
            ((aen[i] && sa[i*RW +: RW] == d) || (ben[i] && sb[i*RW +: RW] == d)))
          r[i] = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [CW-1:0] ref_cnt(logic [N-1:0] r);
    logic [CW-1:0] c = CW'(N);
    for (int i = N - 1; i >= 0; i--)
      if (r[i] || !vld[i]) c = CW'(i);
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr();
    vld = '1; den = '0; aen = '0; ben = '0; dst = '0; sa = '0; sb = '0;
  endtask

  task automatic put(int s, logic [RW-1:0] d, logic de, logic [RW-1:0] a, logic ae,
                     logic [RW-1:0] b, logic be);
    dst[s*RW +: RW] = d; den[s] = de;
    sa[s*RW +: RW]  = a; aen[s] = ae;
    sb[s*RW +: RW]  = b; ben[s] = be;
  endtask

  task automatic shuffle();
    for (int s = 0; s < N; s++) begin
      vld[s] = ($urandom % 8) != 0;
      put(s, RW'($urandom), ($urandom % 4) != 0, RW'($urandom), ($urandom % 4) != 0,
          RW'($urandom), ($urandom % 4) != 0);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic send(string tag);
    logic [N-1:0] r;
    r = ref_raw();
    in_valid = 1'b1;
    q_raw.push_back(r);
    q_cnt.push_back(ref_cnt(r));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_raw.size() == 0) begin
        check("R2 unexpected result", 32'(out_valid), 32'(0));
      end else begin
        logic [N-1:0]  er;
        logic [CW-1:0] ec;
        string         t;
        er = q_raw.pop_front();
        ec = q_cnt.pop_front();
        t  = q_tag.pop_front();
        check({t, " raw_hit"}, 32'(raw_hit), 32'(er));
        check({t, " R8 issue_cnt"}, 32'(issue_cnt), 32'(ec));
        check("R4 slot0", 32'(raw_hit[0]), 32'(0));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]  hold_raw;
    logic [CW-1:0] hold_cnt;

    // R1: reset dominates a live group
    clr();
    put(0, 3'd5, 1, 3'd0, 0, 3'd0, 0);
    put(1, 3'd0, 0, 3'd5, 1, 3'd0, 0);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'(0));
    check("R1 raw_hit", 32'(raw_hit), 32'(0));
    check("R1 issue_cnt", 32'(issue_cnt), 32'(0));
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // R3: source B only match, slot 0 -> slot 2
    clr(); put(0, 3'd5, 1, 3'd1, 1, 3'd2, 1); put(2, 3'd3, 1, 3'd6, 1, 3'd5, 1);
    send("R3 srcB");
    // R3: source A match adjacent
    clr(); put(1, 3'd4, 1, 3'd0, 0, 3'd0, 0); put(2, 3'd0, 0, 3'd4, 1, 3'd0, 0);
    send("R3 srcA");
    // R5: register zero never matches
    clr(); put(0, 3'd0, 1, 3'd0, 1, 3'd0, 1); put(3, 3'd1, 1, 3'd0, 1, 3'd0, 1);
    send("R5 zero");
    // R6: disabled destination, then disabled source
    clr(); put(0, 3'd3, 0, 3'd0, 0, 3'd0, 0); put(1, 3'd2, 1, 3'd3, 1, 3'd3, 1);
    send("R6 dst_en");
    clr(); put(0, 3'd3, 1, 3'd0, 0, 3'd0, 0); put(1, 3'd2, 1, 3'd3, 0, 3'd3, 0);
    send("R6 src_en");
    // R7: WAR and WAW lookalikes
    clr(); put(0, 3'd6, 1, 3'd2, 1, 3'd7, 1); put(1, 3'd2, 1, 3'd1, 1, 3'd1, 1);
    put(2, 3'd6, 1, 3'd3, 1, 3'd4, 1); put(3, 3'd7, 1, 3'd5, 1, 3'd5, 1);
    send("R7 war_waw");
    // R4: slot 0 reads what everyone writes
    clr(); put(0, 3'd1, 1, 3'd2, 1, 3'd3, 1); put(1, 3'd2, 1, 3'd0, 0, 3'd0, 0);
    put(2, 3'd3, 1, 3'd0, 0, 3'd0, 0);
    send("R4 oldest");
    // R8: invalid slot ends the run, all clear, slot 0 invalid
    clr(); vld = 4'b1011; send("R8 invalid2");
    clr(); send("R8 full");
    clr(); vld = 4'b1110; send("R8 invalid0");
    clr(); put(0, 3'd7, 1, 3'd0, 0, 3'd0, 0); put(3, 3'd0, 0, 3'd0, 0, 3'd7, 1);
    send("R8 last");
    // R9: invalid writer still flags
    clr(); vld = 4'b1110; put(0, 3'd2, 1, 3'd0, 0, 3'd0, 0); put(1, 3'd0, 0, 3'd2, 1, 3'd0, 0);
    send("R9 invalid writer");

    // R10: hold while idle, with inputs churning
    clr(); put(0, 3'd4, 1, 3'd0, 0, 3'd0, 0); put(1, 3'd0, 0, 3'd4, 1, 3'd0, 0);
    hold_raw = ref_raw();
    hold_cnt = ref_cnt(hold_raw);
    send("R3 before hold");
    in_valid = 1'b0;
    shuffle();
    @(negedge clk);
    shuffle();
    @(negedge clk);
    check("R2 idle out_valid", 32'(out_valid), 32'(0));
    check("R10 raw_hit", 32'(raw_hit), 32'(hold_raw));
    check("R10 issue_cnt", 32'(issue_cnt), 32'(hold_cnt));

    // random sweep
    for (int k = 0; k < 3000; k++) begin
      shuffle();
      send("R3 random");
      if ($urandom % 16 == 0) idle(1 + ($urandom % 3));
    end
    idle(3);
    check("R2 drained", 32'(q_raw.size()), 32'(0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule